// File: doc/BRIEF.md
# Replacement-Interval Memory Demand Estimator

This block estimates how much cache capacity one processor currently needs, using only the spacing of replacements in its private cache. A small timer counts enabled ticks since the most recent replacement. Each replacement folds that gap into a smoothed demand value, three parts old estimate to one part new gap, and then restarts the timer. A low demand value means replacements come close together, so the processor needs more memory. A high value means the cache has capacity to spare.

The demand value is presented to peer caches. A built-in comparator takes a peer's demand value and a programmable factor. It reports whether the peer is lighter than the local cache by at least that factor, meaning the peer's value is at least the factor times the local value. A victim-placement policy can use that flag to decide whether to send a displaced line to that peer.

Top module: `repl_demand_est`

## Requirements
- R1: While `rst` is high at a clock edge, `elapsed` becomes 0, `demand_hist` becomes 255 (all ones, lowest demand) and `peer_lighter` becomes 0.
- R2: With `repl_evt` low, `elapsed` rises by exactly one per clock edge while `tick_en` is high, and holds its value while `tick_en` is low.
- R3: `elapsed` saturates at 255: further ticks without a replacement leave it at 255 and never wrap it to 0.
- R4: A clock edge with `repl_evt` high sets `elapsed` to 0, whatever `tick_en` is.
- R5: A clock edge with `repl_evt` high loads `demand_hist` with floor((3 × old `demand_hist` + `elapsed`) / 4). Both operands are the values shown on the outputs in the cycle before that edge. The result always lies between the smaller and the larger of those two operands.
- R6: `demand_hist` changes only on an edge where `repl_evt` is high.
- R7: After each clock edge, `peer_lighter` equals (`peer_hist` ≥ `factor_w` × `demand_hist`), using the input and output values before that edge. The product is exact at 12 bits and is never truncated, so `factor_w` = 0 always gives 1.
- R8: When `tick_en` and `repl_evt` are both high in the same cycle, the history update uses the un-incremented `elapsed`, and `elapsed` becomes 0 rather than 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advances the interval timer by one |
| repl_evt | input | 1 | A replacement occurred in this cache this cycle |
| peer_hist | input | 8 | Demand value received from a peer cache |
| factor_w | input | 4 | Factor by which the peer must be lighter |
| elapsed | output | 8 | Saturating ticks since the last replacement |
| demand_hist | output | 8 | Smoothed replacement-interval history (demand estimate) |
| peer_lighter | output | 1 | Registered result: the peer is lighter by the factor |

## Verification
A replacement and a timer tick can land in the same cycle. The history must then absorb the gap as it stood before the tick, and the timer must restart at zero rather than one. The bench provokes this by sweeping gap lengths from 0 up past saturation and ending every other gap with the tick enable held high during the replacement. It predicts the new history arithmetically from the elapsed value it last read at the ports. The comparator is also swept across every factor and peer value against both large and very small local histories, to expose any narrowing of the product.

// File: rtl/repl_demand_pkg.sv
package repl_demand_pkg;

  // Default widths shared by the estimator and its bench-facing checker.
  localparam int unsigned DEMAND_W = 8;  // timer and history width
  localparam int unsigned FACTOR_W = 4;  // comparator factor width

  // Weighting of the smoother: old history counts OLD_PARTS of every
  // (1 << AVG_SHIFT) parts, the fresh interval counts the remainder.
  localparam int unsigned AVG_SHIFT = 2;
  localparam int unsigned OLD_PARTS = 3;

endpackage

// File: rtl/repl_interval_timer.sv
module repl_interval_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic         repl_evt,
  output logic [W-1:0] count_q
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic at_max;
  assign at_max = (count_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (repl_evt) begin
      // restart takes priority over a coincident tick
      count_q <= '0;
    end else if (tick_en && !at_max) begin
      count_q <= count_q + 1'b1;
    end
  end

endmodule

// File: rtl/repl_history_smoother.sv
module repl_history_smoother
  import repl_demand_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         repl_evt,
  input  logic [W-1:0] interval,
  output logic [W-1:0] hist_q
);

  // Sum width holds OLD_PARTS*max + max = (1<<AVG_SHIFT)*max without loss.
  localparam int unsigned SW = W + AVG_SHIFT;

  logic [SW-1:0] weighted_old;
  logic [SW-1:0] sum;
  logic [W-1:0]  avg;

  assign weighted_old = SW'(OLD_PARTS) * {{AVG_SHIFT{1'b0}}, hist_q};
  assign sum          = weighted_old + {{AVG_SHIFT{1'b0}}, interval};
  assign avg          = sum[SW-1:AVG_SHIFT];

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '1;
    end else if (repl_evt) begin
      hist_q <= avg;
    end
  end

endmodule

// File: rtl/peer_demand_cmp.sv
module peer_demand_cmp #(
  parameter int unsigned W  = 8,
  parameter int unsigned FW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  local_hist,
  input  logic [W-1:0]  peer_hist,
  input  logic [FW-1:0] factor,
  output logic          lighter_q
);

  localparam int unsigned PW = W + FW;

  logic [PW-1:0] scaled_local;
  logic [PW-1:0] peer_ext;

  assign scaled_local = {{FW{1'b0}}, local_hist} * {{W{1'b0}}, factor};
  assign peer_ext     = {{FW{1'b0}}, peer_hist};

  always_ff @(posedge clk) begin
    if (rst) begin
      lighter_q <= 1'b0;
    end else begin
      lighter_q <= (peer_ext >= scaled_local);
    end
  end

endmodule

// File: rtl/repl_demand_est.sv
module repl_demand_est
  import repl_demand_pkg::*;
#(
  parameter int unsigned W  = DEMAND_W,
  parameter int unsigned FW = FACTOR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          repl_evt,
  input  logic [W-1:0]  peer_hist,
  input  logic [FW-1:0] factor_w,
  output logic [W-1:0]  elapsed,
  output logic [W-1:0]  demand_hist,
  output logic          peer_lighter
);

  logic [W-1:0] gap_cnt;
  logic [W-1:0] hist_val;
  logic         lighter;

  repl_interval_timer #(.W(W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .repl_evt (repl_evt),
    .count_q  (gap_cnt)
  );

  repl_history_smoother #(.W(W)) u_smooth (
    .clk      (clk),
    .rst      (rst),
    .repl_evt (repl_evt),
    .interval (gap_cnt),
    .hist_q   (hist_val)
  );

  peer_demand_cmp #(.W(W), .FW(FW)) u_cmp (
    .clk        (clk),
    .rst        (rst),
    .local_hist (hist_val),
    .peer_hist  (peer_hist),
    .factor     (factor_w),
    .lighter_q  (lighter)
  );

  assign elapsed      = gap_cnt;
  assign demand_hist  = hist_val;
  assign peer_lighter = lighter;

endmodule

// File: rtl/repl_demand_est_chk.sv
module repl_demand_est_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned FW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          tick_en,
  input logic          repl_evt,
  input logic [W-1:0]  peer_hist,
  input logic [FW-1:0] factor_w,
  input logic [W-1:0]  elapsed,
  input logic [W-1:0]  demand_hist,
  input logic          peer_lighter
);

  localparam logic [W-1:0] TOP = '1;

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !repl_evt && elapsed != TOP) |=> (elapsed == $past(elapsed) + 1'b1));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !repl_evt) |=> $stable(elapsed));

  // R3
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (elapsed == TOP && !repl_evt) |=> (elapsed == TOP));

  // R4
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    repl_evt |=> (elapsed == '0));

  // R5
  hist_bounded_chk: assert property (@(posedge clk) disable iff (rst)
    repl_evt |=> ((demand_hist <= (($past(demand_hist) > $past(elapsed)) ? $past(demand_hist) : $past(elapsed)))
               && (demand_hist >= (($past(demand_hist) < $past(elapsed)) ? $past(demand_hist) : $past(elapsed)))));

  // R6
  hist_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !repl_evt |=> $stable(demand_hist));

  // R7
  zero_factor_chk: assert property (@(posedge clk) disable iff (rst)
    (factor_w == '0) |=> peer_lighter);

endmodule

bind repl_demand_est repl_demand_est_chk #(.W(W), .FW(FW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tick_en      (tick_en),
  .repl_evt     (repl_evt),
  .peer_hist    (peer_hist),
  .factor_w     (factor_w),
  .elapsed      (elapsed),
  .demand_hist  (demand_hist),
  .peer_lighter (peer_lighter)
);

// File: tb/repl_demand_est_test.sv
`timescale 1ns/1ps
module repl_demand_est_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       tick_en;
  logic       repl_evt;
  logic [7:0] peer_hist;
  logic [3:0] factor_w;
  logic [7:0] elapsed;
  logic [7:0] demand_hist;
  logic       peer_lighter;

  always #2.5 clk = ~clk;

  repl_demand_est uut (
    .clk          (clk),
    .rst          (rst),
    .tick_en      (tick_en),
    .repl_evt     (repl_evt),
    .peer_hist    (peer_hist),
    .factor_w     (factor_w),
    .elapsed      (elapsed),
    .demand_hist  (demand_hist),
    .peer_lighter (peer_lighter)
  );

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 0;
  int  m_cnt;
  int  m_hist;
  int  m_low;

  task automatic cmp(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    cmp({tag, " elapsed"}, int'(elapsed), m_cnt);
    cmp({tag, " demand_hist"}, int'(demand_hist), m_hist);
    cmp({tag, " peer_lighter"}, int'(peer_lighter), m_low);
  endtask

  // Called at a negedge: drive, predict, clock once, compare at next negedge.
  task automatic step(bit t, bit r, int p, int w, string tag);
    int n_cnt, n_hist, n_low;
    tick_en   = t;
    repl_evt  = r;
    peer_hist = 8'(p);
    factor_w  = 4'(w);
    n_hist = r ? (3 * m_hist + m_cnt) / 4 : m_hist;
    n_cnt  = r ? 0 : ((t && m_cnt < 255) ? m_cnt + 1 : m_cnt);
    n_low  = (p >= w * m_hist) ? 1 : 0;
    @(posedge clk);
    @(negedge clk);
    m_cnt = n_cnt; m_hist = n_hist; m_low = n_low;
    check_all(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tick_en = 1'b1; repl_evt = 1'b1; peer_hist = 8'd0; factor_w = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_cnt = 0; m_hist = 255; m_low = 0;
    check_all("R1 reset");
    rst = 1'b0;

    // R2: counting and holding
    for (int i = 0; i < 10; i++) step(1, 0, 0, 1, "R2 tick");
    for (int i = 0; i < 5; i++)  step(0, 0, 0, 1, "R2 hold");
    for (int i = 0; i < 20; i++) step(i % 3 != 0, 0, 0, 1, "R2 mixed");

    // R3: saturation
    for (int i = 0; i < 260; i++) step(1, 0, 0, 1, "R3 saturate");
    cmp("R3 at max", int'(elapsed), 255);

    // R4 / R5: replacement without tick, then with tick (R8)
    step(0, 1, 0, 1, "R4 R5 replace");
    for (int i = 0; i < 7; i++) step(1, 0, 0, 1, "R2 regrow");
    step(1, 1, 0, 1, "R8 coincident");
    cmp("R8 elapsed restart", int'(elapsed), 0);

    // R5 / R6 / R8 sweep over gap lengths, including saturated ones
    for (int k = 0; k < 300; k++) begin
      for (int j = 0; j < k; j++) step(1, 0, 0, 1, "R6 gap");
      step(k % 2, 1, 0, 1, "R5 sweep");
    end

    // R7: full factor and peer sweep at the current history
    for (int w = 0; w < 16; w++)
      for (int p = 0; p < 256; p++) step(0, 0, p, w, "R7 sweep hi");

    // drive history large again, then check the product is not truncated
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 255; j++) step(1, 0, 0, 1, "R3 refill");
      step(0, 1, 0, 1, "R5 refill");
    end
    for (int i = 0; i < 40; i++) step(1, 0, 0, 1, "R3 refill2");
    step(0, 1, 0, 1, "R5 refill2");
    step(0, 0, 255, 15, "R7 wide product");
    step(0, 0, 255, 1, "R7 equal");

    // back-to-back replacements drive the history toward full demand
    for (int i = 0; i < 40; i++) step(0, 1, 3, 2, "R5 shrink");
    for (int w = 0; w < 16; w++)
      for (int p = 0; p < 40; p++) step(0, 0, p, w, "R7 sweep lo");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule